// File: doc/BRIEF.md
# Deferred-Response SPI Register Slave

This block is a serial register port for a motor-driver controller. An external SPI master exchanges 16-bit frames with it. Each incoming frame carries an access type, a register address and eleven data bits. The word that comes back in the same frame is not the answer to that frame. It answers the command from the previous completed frame, so a master that wants a value sends the read and then collects the answer during its next transfer.

Behind the port sit four registers. Two are read-only status registers that collect fault events from the power stage and keep them until they are read. Two are read/write control registers whose values drive the output pins. A status read clears the fault bits it reported, but only once the frame that carries them out has completed. A fault that arrives after the read was decoded is kept for the next read.

The SPI pins are oversampled by the system clock through synchronizer stages. SCLK idles low. MOSI is sampled on SCLK rising edges, and MISO advances on SCLK falling edges.

Top module: `fault_spi_regs`

## Requirements
- R1: A frame is 16 SCLK periods framed by CS low, shifted MSB first. The MSB of the outgoing word is on MISO before the first rising edge. Each later bit follows a falling edge. MISO is 0 while CS is high.
- R2: The word returned during a frame answers the last completed command before it. Until the first completed frame after reset, the returned word is 0x0000.
- R3: In the incoming word, bit 15 = 1 requests a read and 0 requests a write. Bits 14:11 are the address and bits 10:0 are the data.
- R4: In the response, bits 14:11 repeat the address of the answered command and bits 10:0 carry the register value. Bit 15 is 1 when any status fault bit is latched after the clear at the end of that command's frame.
- R5: Addresses 2 and 3 are control registers 1 and 2. After reset they hold the parameter values CTRL1_RST and CTRL2_RST and appear on ctrl1_q and ctrl2_q. A write updates the register, and the response to the write carries the value written.
- R6: Address 0 is status register 1. From bit 10 down to bit 0 it holds: any-fault, gate-drive undervoltage, supply undervoltage, over-temperature shutdown, over-temperature warning, then overcurrent for phase A high, A low, B high, B low, C high and C low. The any-fault bit is set by any fault input, including gate-drive overvoltage. Each bit stays set from the cycle after its input is high until it is cleared by a read.
- R7: Address 1 is status register 2. Bit 7 is the latched gate-drive overvoltage, bits 3:0 are the DEV_ID parameter, and every other bit is 0.
- R8: A read of a status register clears the fault bits it reported at the end of the next completed frame. A fault that occurs after the read frame ends is set again and is not lost.
- R9: A frame that ends with any SCLK count other than 16 writes nothing and clears nothing. The pending response stays as it was.
- R10: Writes to addresses 0, 1 and 4 to 15 change no register. Reads and writes of addresses 4 to 15 return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial response data |
| flt_ocp | input | 6 | Overcurrent events, bit 5 = A high down to bit 0 = C low |
| flt_gate_uv | input | 1 | Gate-drive undervoltage event |
| flt_supply_uv | input | 1 | Supply undervoltage event |
| flt_ot_shut | input | 1 | Over-temperature shutdown event |
| flt_ot_warn | input | 1 | Over-temperature warning event |
| flt_gate_ov | input | 1 | Gate-drive overvoltage event |
| ctrl1_q | output | 11 | Control register 1 contents |
| ctrl2_q | output | 11 | Control register 2 contents |

## Verification
The bench builds the block with DEV_ID = 4'h9, CTRL1_RST = 11'h2A5, CTRL2_RST = 11'h013 and two synchronizer stages. The non-zero, distinct reset values make an early read of either control register tell them apart from zero data and from each other. The unusual ID bits show whether status register 2 carries its identifier in the right field. The SPI half period of eight system clocks leaves room for the synchronizer delay. That room lets faults be injected in the middle of a frame, which exercises the re-set-during-clear case, and lets frames be cut short or run long to check abort handling.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 11;
  localparam int OCP_W   = 6;
  localparam int FIN_W   = OCP_W + 4;
  localparam int ID_W    = 4;
  localparam int N_CTRL  = 2;

  localparam logic [ADDR_W-1:0] ADDR_STAT1     = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT2     = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL_BASE = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL_END  = ADDR_W'(int'(ADDR_CTRL_BASE) + N_CTRL);

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  typedef enum logic [1:0] {
    SEL_STAT1 = 2'd0,
    SEL_STAT2 = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } sel_e;

  function automatic cmd_t unpack_cmd(input logic [FRAME_W-1:0] w);
    cmd_t c;
    c.rd   = w[FRAME_W-1];
    c.addr = w[FRAME_W-2 -: ADDR_W];
    c.data = w[DATA_W-1:0];
    return c;
  endfunction

  function automatic sel_e decode_addr(input logic [ADDR_W-1:0] a);
    if (a == ADDR_STAT1) return SEL_STAT1;
    if (a == ADDR_STAT2) return SEL_STAT2;
    if (a >= ADDR_CTRL_BASE && a < ADDR_CTRL_END) return SEL_CTRL;
    return SEL_NONE;
  endfunction

  function automatic logic [FRAME_W-1:0] pack_resp(input logic f0,
                                                   input logic [ADDR_W-1:0] a,
                                                   input logic [DATA_W-1:0] d);
    return {f0, a, d};
  endfunction

  // any-fault bit on top of the raw event bits
  function automatic logic [DATA_W-1:0] fault_set_vec(input logic [FIN_W-1:0] fin,
                                                      input logic ov);
    return {(|fin) | ov, fin};
  endfunction

  function automatic logic [DATA_W-1:0] stat2_word(input logic ov,
                                                   input logic [ID_W-1:0] id);
    return {3'b000, ov, 3'b000, id};
  endfunction
endpackage

// File: rtl/spireg_frame_port.sv
module spireg_frame_port #(
  parameter int FRAME_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               mosi,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               miso,
  output logic [FRAME_W-1:0] rx_word,
  output logic               frame_end,
  output logic               frame_ok
);
  localparam int CNT_W = $clog2(FRAME_W) + 2;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [SYNC_STAGES-1:0] sclk_sync, cs_sync, mosi_sync;
  logic sclk_s, cs_s, mosi_s, sclk_d, cs_d;
  logic sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic [FRAME_W-1:0] rx_sr, tx_sr;
  logic [CNT_W-1:0]   bit_cnt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclk_sync <= '0;
          cs_sync   <= '1;
          mosi_sync <= '0;
        end else begin
          sclk_sync <= sclk;
          cs_sync   <= cs_n;
          mosi_sync <= mosi;
        end
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclk_sync <= '0;
          cs_sync   <= '1;
          mosi_sync <= '0;
        end else begin
          sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk};
          cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
          mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi};
        end
      end
    end
  endgenerate

  assign sclk_s = sclk_sync[SYNC_STAGES-1];
  assign cs_s   = cs_sync[SYNC_STAGES-1];
  assign mosi_s = mosi_sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_fall   = ~cs_s & cs_d;
  assign cs_rise   = cs_s & ~cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr   <= '0;
      tx_sr   <= '0;
      bit_cnt <= '0;
    end else if (cs_fall) begin
      tx_sr   <= tx_word;
      bit_cnt <= '0;
    end else if (cs_rise) begin
      tx_sr   <= '0;
    end else if (!cs_s) begin
      if (sclk_rise) begin
        rx_sr <= {rx_sr[FRAME_W-2:0], mosi_s};
        if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
      end
      if (sclk_fall) tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
    end
  end

  assign miso      = ~cs_s & tx_sr[FRAME_W-1];
  assign rx_word   = rx_sr;
  assign frame_end = cs_rise;
  assign frame_ok  = cs_rise && (bit_cnt == CNT_FULL);
endmodule

// File: rtl/spireg_fault_latch.sv
module spireg_fault_latch
  import spireg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FIN_W-1:0]  fault_in,
  input  logic              ov_in,
  input  logic              frame_ok,
  input  logic              rd_s1,
  input  logic              rd_s2,
  output logic [DATA_W-1:0] s1_q,
  output logic              ov_q,
  output logic [DATA_W-1:0] s1_now,
  output logic              ov_now,
  output logic              clear_now,
  output logic              fault_any
);
  logic [DATA_W-1:0] set_vec, fresh1, mask1, s1_base;
  logic              fresh_ov, mask_ov, ov_base;

  assign set_vec   = fault_set_vec(fault_in, ov_in);
  assign fault_any = set_vec[DATA_W-1];
  assign clear_now = frame_ok & ((|mask1) | mask_ov);

  always_comb begin
    s1_base = s1_q;
    ov_base = ov_q;
    if (frame_ok) begin
      s1_base = (s1_q & ~mask1) | fresh1;
      ov_base = (ov_q & ~mask_ov) | fresh_ov;
    end
    s1_now = s1_base | set_vec;
    ov_now = ov_base | ov_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q     <= '0;
      ov_q     <= 1'b0;
      fresh1   <= '0;
      fresh_ov <= 1'b0;
      mask1    <= '0;
      mask_ov  <= 1'b0;
    end else begin
      s1_q <= s1_now;
      ov_q <= ov_now;
      if (frame_ok) begin
        fresh1   <= set_vec;
        fresh_ov <= ov_in;
        mask1    <= rd_s1 ? s1_now : '0;
        mask_ov  <= rd_s2 & ov_now;
      end else begin
        fresh1   <= fresh1 | set_vec;
        fresh_ov <= fresh_ov | ov_in;
      end
    end
  end
endmodule

// File: rtl/spireg_ctrl_bank.sv
module spireg_ctrl_bank #(
  parameter int N  = 2,
  parameter int DW = 11,
  parameter int AW = 4,
  parameter logic [AW-1:0]   BASE = 2,
  parameter logic [N*DW-1:0] RST  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [N*DW-1:0] q_flat
);
  logic [DW-1:0] q [N];

  for (genvar k = 0; k < N; k++) begin : g_reg
    localparam logic [AW-1:0] MY_ADDR = AW'(int'(BASE) + k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[k] <= RST[k*DW +: DW];
      else if (wr_en && addr == MY_ADDR) q[k] <= wr_data;
    end
    assign q_flat[k*DW +: DW] = q[k];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < N; k++)
      if (addr == AW'(int'(BASE) + k)) rd_data = q[k];
  end
endmodule

// File: rtl/fault_spi_regs.sv
module fault_spi_regs
  import spireg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [ID_W-1:0]   DEV_ID    = 4'h5,
  parameter logic [DATA_W-1:0] CTRL1_RST = '0,
  parameter logic [DATA_W-1:0] CTRL2_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [OCP_W-1:0]  flt_ocp,
  input  logic              flt_gate_uv,
  input  logic              flt_supply_uv,
  input  logic              flt_ot_shut,
  input  logic              flt_ot_warn,
  input  logic              flt_gate_ov,
  output logic [DATA_W-1:0] ctrl1_q,
  output logic [DATA_W-1:0] ctrl2_q
);
  logic [FRAME_W-1:0] rx_word, resp_q;
  logic               frame_end, frame_ok;
  cmd_t               cmd;
  sel_e               sel;
  logic               cmd_rd;
  logic [ADDR_W-1:0]  cmd_addr;
  logic               wr_ctrl, rd_s1, rd_s2;
  logic [DATA_W-1:0]  s1_q, s1_now, ctrl_rd, resp_data;
  logic               ov_q, ov_now, clear_now, fault_any;
  logic [FIN_W-1:0]   fault_in;
  logic [N_CTRL*DATA_W-1:0] ctrl_flat;

  spireg_frame_port #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) u_port (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_word(resp_q), .miso(spi_miso), .rx_word(rx_word),
    .frame_end(frame_end), .frame_ok(frame_ok)
  );

  assign cmd      = unpack_cmd(rx_word);
  assign sel      = decode_addr(cmd.addr);
  assign cmd_rd   = cmd.rd;
  assign cmd_addr = cmd.addr;
  assign wr_ctrl  = frame_ok & ~cmd.rd & (sel == SEL_CTRL);
  assign rd_s1    = cmd.rd & (sel == SEL_STAT1);
  assign rd_s2    = cmd.rd & (sel == SEL_STAT2);
  assign fault_in = {flt_gate_uv, flt_supply_uv, flt_ot_shut, flt_ot_warn, flt_ocp};

  spireg_fault_latch u_faults (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .ov_in(flt_gate_ov),
    .frame_ok(frame_ok), .rd_s1(rd_s1), .rd_s2(rd_s2),
    .s1_q(s1_q), .ov_q(ov_q), .s1_now(s1_now), .ov_now(ov_now),
    .clear_now(clear_now), .fault_any(fault_any)
  );

  spireg_ctrl_bank #(
    .N(N_CTRL), .DW(DATA_W), .AW(ADDR_W), .BASE(ADDR_CTRL_BASE),
    .RST({CTRL2_RST, CTRL1_RST})
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .addr(cmd.addr),
    .wr_data(cmd.data), .rd_data(ctrl_rd), .q_flat(ctrl_flat)
  );

  assign ctrl1_q = ctrl_flat[DATA_W-1:0];
  assign ctrl2_q = ctrl_flat[2*DATA_W-1:DATA_W];

  always_comb begin
    unique case (sel)
      SEL_STAT1: resp_data = s1_now;
      SEL_STAT2: resp_data = stat2_word(ov_now, DEV_ID);
      SEL_CTRL:  resp_data = cmd.rd ? ctrl_rd : cmd.data;
      default:   resp_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_q <= '0;
    else if (frame_ok) resp_q <= pack_resp((|s1_now) | ov_now, cmd.addr, resp_data);
  end
endmodule

// File: rtl/fault_spi_regs_checker.sv
module fault_spi_regs_checker
  import spireg_pkg::*;
#(
  parameter logic [ID_W-1:0] DEV_ID = 4'h5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     frame_ok,
  input logic                     cmd_rd,
  input logic [ADDR_W-1:0]        cmd_addr,
  input logic [FRAME_W-1:0]       resp_q,
  input logic [N_CTRL*DATA_W-1:0] ctrl_flat,
  input logic [DATA_W-1:0]        s1_q,
  input logic                     fault_any,
  input logic                     clear_now
);
  logic ctrl_write;
  assign ctrl_write = frame_ok && !cmd_rd &&
                      cmd_addr >= ADDR_CTRL_BASE && cmd_addr < ADDR_CTRL_END;

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_write |=> $stable(ctrl_flat)); // R10
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_now |=> ((s1_q & $past(s1_q)) == $past(s1_q))); // R6
  AST_ANY_FAULT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |=> s1_q[DATA_W-1]); // R6
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> $stable(resp_q)); // R9
  AST_ADDR_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> resp_q[FRAME_W-2 -: ADDR_W] == $past(cmd_addr)); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && cmd_addr >= ADDR_CTRL_END |=> resp_q[DATA_W-1:0] == '0); // R10
  AST_DEVICE_ID: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && cmd_addr == ADDR_STAT2 |=> resp_q[ID_W-1:0] == DEV_ID); // R7
endmodule

bind fault_spi_regs fault_spi_regs_checker #(.DEV_ID(DEV_ID)) u_checker (
  .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .cmd_rd(cmd_rd),
  .cmd_addr(cmd_addr), .resp_q(resp_q), .ctrl_flat(ctrl_flat),
  .s1_q(s1_q), .fault_any(fault_any), .clear_now(clear_now)
);

// File: tb/fault_spi_regs_bench.sv
module fault_spi_regs_bench;
  localparam logic [3:0]  P_ID   = 4'h9;
  localparam logic [10:0] P_C1   = 11'h2A5;
  localparam logic [10:0] P_C2   = 11'h013;
  localparam int          HALF   = 8;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, cs_n = 1, mosi = 0;
  logic miso;
  logic [5:0] ocp = 0;
  logic g_uv = 0, s_uv = 0, ot_s = 0, ot_w = 0, g_ov = 0;
  logic [10:0] c1, c2;

  always #10 clk = ~clk;

  fault_spi_regs #(.SYNC_STAGES(2), .DEV_ID(P_ID), .CTRL1_RST(P_C1), .CTRL2_RST(P_C2))
  u_fault_spi_regs (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .flt_ocp(ocp), .flt_gate_uv(g_uv), .flt_supply_uv(s_uv),
    .flt_ot_shut(ot_s), .flt_ot_warn(ot_w), .flt_gate_ov(g_ov),
    .ctrl1_q(c1), .ctrl2_q(c2)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [10:0] m_ctrl [2];
  logic [10:0] m_s1, m_f1, m_mask1;
  logic        m_ov, m_fov, m_maskov;
  logic [15:0] m_pend;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_faults(input logic [10:0] fv);
    g_ov = fv[10]; g_uv = fv[9]; s_uv = fv[8]; ot_s = fv[7]; ot_w = fv[6]; ocp = fv[5:0];
  endtask

  task automatic model_fault(input logic [10:0] fv);
    logic [10:0] setv;
    setv = {|fv, fv[9:0]};
    if (fv != 0) begin
      m_s1 |= setv; m_f1 |= setv;
      m_ov |= fv[10]; m_fov |= fv[10];
    end
  endtask

  task automatic model_end(input logic [15:0] cmd);
    logic rd; logic [3:0] a; logic [10:0] d, val;
    m_s1 = (m_s1 & ~m_mask1) | m_f1;
    m_ov = (m_ov & ~m_maskov) | m_fov;
    m_f1 = 0; m_fov = 0; m_mask1 = 0; m_maskov = 0;
    rd = cmd[15]; a = cmd[14:11]; d = cmd[10:0];
    case (a)
      4'd0: begin val = m_s1; if (rd) m_mask1 = m_s1; end
      4'd1: begin val = {3'b0, m_ov, 3'b0, P_ID}; if (rd) m_maskov = m_ov; end
      4'd2, 4'd3: begin
        if (!rd) m_ctrl[a[0]] = d;
        val = m_ctrl[a[0]];
      end
      default: val = 0;
    endcase
    m_pend = {(|m_s1) | m_ov, a, val};
  endtask

  task automatic pulse_fault(input logic [10:0] fv);
    @(negedge clk) drive_faults(fv);
    model_fault(fv);
    repeat (2) @(negedge clk);
    drive_faults(0);
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] cmd, input int nbits, input logic [10:0] mid,
                       output logic [15:0] got);
    got = 0;
    @(negedge clk) cs_n = 0;
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? cmd[15-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 16) got[15-i] = miso;
      sclk = 1;
      if (i == 8 && mid != 0) begin drive_faults(mid); model_fault(mid); end
      repeat (HALF) @(negedge clk);
      if (i == 8) drive_faults(0);
      sclk = 0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (HALF + 2) @(negedge clk);
    if (nbits == 16) model_end(cmd);
  endtask

  // full frame with comparison of the returned word against the model
  task automatic xfer(input string req, input logic rd, input logic [3:0] a,
                      input logic [10:0] d, input logic [10:0] mid);
    logic [15:0] got, exp;
    exp = m_pend;
    frame({rd, a, d}, 16, mid, got);
    check(req, got, exp);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    void'($urandom(32'h5EED_0042));
    m_ctrl[0] = P_C1; m_ctrl[1] = P_C2;
    m_s1 = 0; m_f1 = 0; m_mask1 = 0; m_ov = 0; m_fov = 0; m_maskov = 0; m_pend = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    check("R1 idle miso", {15'b0, miso}, 16'h0);
    check("R5 ctrl1 reset", {5'b0, c1}, {5'b0, P_C1});
    check("R5 ctrl2 reset", {5'b0, c2}, {5'b0, P_C2});

    // R2: first response is zero; R3 read of ctrl1
    xfer("R2 first word zero", 1'b1, 4'd2, 11'h7FF, 0);
    check("R2 model first", m_pend, {1'b0, 4'd2, P_C1});
    xfer("R5 ctrl1 read answered", 1'b0, 4'd3, 11'h5A3, 0);
    check("R5 ctrl2 written", {5'b0, c2}, 16'h05A3);
    xfer("R5 write response echoes data", 1'b1, 4'd3, 11'h000, 0);
    check("R1 idle after frame", {15'b0, miso}, 16'h0);

    // R6 / R7 / R8: faults, sticky, clear on read
    pulse_fault(11'b1_0_0_0_0_100000);   // gate ov + phase A high overcurrent
    xfer("R5 ctrl2 read", 1'b1, 4'd0, 11'h0, 0);
    check("R6 status1 word", m_pend, {1'b1, 4'd0, 11'b100_0010_0000});
    xfer("R6 status1 response", 1'b1, 4'd1, 11'h0, 11'b0_0_0_0_0_001000);
    check("R8 re-set during clear frame", m_pend, {1'b1, 4'd1, 3'b0, 1'b1, 3'b0, P_ID});
    xfer("R7 status2 response", 1'b1, 4'd0, 11'h0, 0);
    check("R8 cleared except new fault", m_pend, {1'b1, 4'd0, 11'b100_0000_1000});
    xfer("R8 status1 after clear", 1'b1, 4'd0, 11'h0, 0);
    xfer("R8 status1 fully cleared", 1'b1, 4'd1, 11'h0, 0);
    check("R4 no fault flag", m_pend, {1'b0, 4'd1, 3'b0, 1'b0, 3'b0, P_ID});

    // R9: aborted frames (short and long)
    frame({1'b0, 4'd2, 11'h111}, 12, 0, got);
    check("R9 short frame no write", {5'b0, c1}, {5'b0, P_C1});
    frame({1'b0, 4'd2, 11'h222}, 17, 0, got);
    check("R9 long frame no write", {5'b0, c1}, {5'b0, P_C1});
    xfer("R9 response kept over aborts", 1'b0, 4'd0, 11'h7FF, 0);

    // R10: writes to read-only and unmapped addresses
    xfer("R10 write status1 answered zero", 1'b0, 4'd9, 11'h3FF, 0);
    check("R10 unmapped write data", m_pend, {1'b0, 4'd9, 11'h0});
    xfer("R10 unmapped write response", 1'b1, 4'd0, 11'h0, 0);
    xfer("R10 status1 untouched by write", 1'b1, 4'd15, 11'h0, 0);
    xfer("R10 unmapped read zero", 1'b0, 4'd1, 11'h7FF, 0);
    check("R10 ctrl1 unchanged", {5'b0, c1}, {5'b0, P_C1});
    check("R10 ctrl2 unchanged", {5'b0, c2}, 16'h05A3);

    // random traffic, R3/R4 checked against the model
    for (int n = 0; n < 90; n++) begin
      logic rd; logic [3:0] a; logic [10:0] d, mid; int nb;
      rd = 1'($urandom % 2);
      a = 4'($urandom_range(0, 5) == 5 ? $urandom_range(4, 15) : $urandom_range(0, 3));
      d = 11'($urandom);
      mid = ($urandom % 4 == 0) ? 11'($urandom) : 11'h0;
      nb = 16;
      if ($urandom % 8 == 0) begin nb = $urandom_range(1, 20); if (nb == 16) nb = 15; end
      if ($urandom % 5 == 0) pulse_fault(11'($urandom));
      if (nb == 16) xfer("R3 R4 random frame", rd, a, d, mid);
      else frame({rd, a, d}, nb, mid, got);
      check("R5 random ctrl1", {5'b0, c1}, {5'b0, m_ctrl[0]});
      check("R5 random ctrl2", {5'b0, c2}, {5'b0, m_ctrl[1]});
    end
    xfer("R4 final drain", 1'b1, 4'd2, 11'h0, 0);
    check("R1 idle at end", {15'b0, miso}, 16'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule